// File: doc/BRIEF.md
# BCD Calendar Counter with Full-Match Alarm

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year for 2000 to 2099. It also keeps a binary day-of-week counter. A prescaler divides the 32768 Hz clock into a one-second tick. Every tick advances the time by one second and carries through every field, including month lengths and leap years. The block pulses a strobe for each second, minute, hour and day rollover. It also raises an alarm strobe when the newly counted time equals all six alarm fields. No alarm field can be masked.

A small run-control state machine gates the prescaler. It has two states. `ST_HALT` holds everything still. `ST_RUN` lets the prescaler count. The transition `ST_HALT -> ST_RUN` is taken on the first clock with `run_en` high. The transition `ST_RUN -> ST_HALT` is taken on the first clock with `run_en` low. In every other case the machine stays in its current state.

Software sets the time through a load port. A load overrides the counted value in that cycle and restarts the prescaler, so the first second after a load is a full second long.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, and week day 0. All strobes are low.
- R2: While running, the seconds field advances once every PRESCALE_MAX+1 clock cycles. Each BCD digit goes from 9 to 0 and carries into its upper digit.
- R3: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries one into the next field.
- R4: The day goes back to 01 after the last day of the month. That day is 31, 30 (months 04, 06, 09, 11), or 28 for month 02. Month 02 has 29 days when the year value 00–99 is divisible by four.
- R5: The month counts 01 to 12 and wraps 12 to 01 with a year increment. The year wraps 99 to 00.
- R6: The week day is binary 0 to 6. It steps once on each day rollover and wraps from 6 to 0.
- R7: The strobes `ev_sec`, `ev_min`, `ev_hour` and `ev_day` are each high for exactly one cycle. That cycle is the first cycle in which the new value is visible. A strobe fires only when its own field's lower neighbour wrapped.
- R8: While `run_en` is low, no field changes and no strobe fires.
- R9: `load_en` writes all seven fields in the cycle it is sampled and overrides counting. The next advance comes PRESCALE_MAX+1 cycles after that load edge.
- R10: `alarm_hit` pulses for one cycle together with `ev_sec` when the counted time equals the alarm seconds, minutes, hours, day, month and year. A mismatch in any one field means no pulse. A load that sets a matching time does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | 1 lets time advance, 0 freezes it |
| load_en | input | 1 | Writes the ld_* fields this cycle |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_day | input | 8 | BCD day of month to load |
| ld_mon | input | 8 | BCD month to load (01–12) |
| ld_year | input | 8 | BCD year to load (00–99) |
| ld_wday | input | 3 | Week day to load (0–6) |
| al_sec | input | 8 | BCD alarm seconds |
| al_min | input | 8 | BCD alarm minutes |
| al_hour | input | 8 | BCD alarm hours |
| al_day | input | 8 | BCD alarm day |
| al_mon | input | 8 | BCD alarm month |
| al_year | input | 8 | BCD alarm year |
| tm_sec | output | 8 | Current BCD seconds |
| tm_min | output | 8 | Current BCD minutes |
| tm_hour | output | 8 | Current BCD hours |
| tm_day | output | 8 | Current BCD day |
| tm_mon | output | 8 | Current BCD month |
| tm_year | output | 8 | Current BCD year |
| tm_wday | output | 3 | Current week day |
| ev_sec | output | 1 | One-cycle second strobe |
| ev_min | output | 1 | One-cycle minute-rollover strobe |
| ev_hour | output | 1 | One-cycle hour-rollover strobe |
| ev_day | output | 1 | One-cycle day-rollover strobe |
| alarm_hit | output | 1 | One-cycle full-match alarm strobe |

## Verification
The bench builds the block with PRESCALE_MAX set to 3, so one simulated second lasts four clocks. With that setting, each loaded starting time is followed by an exactly timed advance within a few cycles. This puts every month-end, leap-year, year-wrap and week-day case within reach without counting through the full 32768-cycle second. The default of 32767 changes only the prescaler compare width and the length of the wait. The carry chain and alarm paths are the same for both values.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic {ST_HALT, ST_RUN} run_state_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    // {wrapped, next value} for a packed-BCD field running first..last
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] first,
                                            input logic [7:0] last);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] year);
        logic [6:0] ybin;
        ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import cal_pkg::*;
#(
    parameter int PRESCALE_MAX = 32767
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic load,
    output logic tick
);
    localparam int PW = (PRESCALE_MAX < 1) ? 1 : $clog2(PRESCALE_MAX + 1);
    localparam logic [PW-1:0] WRAP_AT = PW'(PRESCALE_MAX);

    run_state_t state_q, state_d;
    logic [PW-1:0] pre_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            ST_HALT: tick = 1'b0;
            ST_RUN:  tick = (pre_q == WRAP_AT) && !load;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (load)             pre_q <= '0;
        else if (state_q == ST_RUN) pre_q <= (pre_q == WRAP_AT) ? '0 : pre_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  cal_time_t ld_time,
    input  logic [2:0] ld_wday,
    output cal_time_t cur,
    output logic [2:0] wday,
    output cal_time_t nxt,
    output logic      ev_sec,
    output logic      ev_min,
    output logic      ev_hour,
    output logic      ev_day
);
    logic [8:0] s_st, m_st, h_st, d_st, mo_st, y_st;
    logic c_min, c_hour, c_day, c_mon, c_year;
    logic [2:0] wday_nxt;

    always_comb begin
        s_st  = bcd_step(cur.sec,  8'h00, 8'h59);
        m_st  = bcd_step(cur.min,  8'h00, 8'h59);
        h_st  = bcd_step(cur.hour, 8'h00, 8'h23);
        d_st  = bcd_step(cur.day,  8'h01, month_last_day(cur.mon, cur.year));
        mo_st = bcd_step(cur.mon,  8'h01, 8'h12);
        y_st  = bcd_step(cur.year, 8'h00, 8'h99);
        c_min  = s_st[8];
        c_hour = c_min  & m_st[8];
        c_day  = c_hour & h_st[8];
        c_mon  = c_day  & d_st[8];
        c_year = c_mon  & mo_st[8];
        nxt.sec  = s_st[7:0];
        nxt.min  = c_min  ? m_st[7:0]  : cur.min;
        nxt.hour = c_hour ? h_st[7:0]  : cur.hour;
        nxt.day  = c_day  ? d_st[7:0]  : cur.day;
        nxt.mon  = c_mon  ? mo_st[7:0] : cur.mon;
        nxt.year = c_year ? y_st[7:0]  : cur.year;
        wday_nxt = c_day ? ((wday == 3'd6) ? 3'd0 : wday + 3'd1) : wday;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01, mon: 8'h01, year: 8'h00};
            wday <= 3'd0;
        end else if (load) begin
            cur  <= ld_time;
            wday <= ld_wday;
        end else if (tick) begin
            cur  <= nxt;
            wday <= wday_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_sec <= 1'b0; ev_min <= 1'b0; ev_hour <= 1'b0; ev_day <= 1'b0;
        end else begin
            ev_sec  <= tick;
            ev_min  <= tick & c_min;
            ev_hour <= tick & c_hour;
            ev_day  <= tick & c_day;
        end
    end

    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(cur) && $stable(wday))); // R8
    AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cur.sec != $past(cur.sec))); // R2
    AST_MIN_EV_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ev_min |-> (ev_sec && cur.sec == 8'h00)); // R3
    AST_DAY_EV_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_day |-> (ev_hour && cur.hour == 8'h00 && cur.min == 8'h00)); // R7
    AST_EV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sec |=> !ev_sec); // R7

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  cal_time_t nxt,
    input  cal_time_t alarm,
    output logic      hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= tick && (nxt == alarm);
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int PRESCALE_MAX = 32767
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_day,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    input  logic [2:0] ld_wday,
    input  logic [7:0] al_sec,
    input  logic [7:0] al_min,
    input  logic [7:0] al_hour,
    input  logic [7:0] al_day,
    input  logic [7:0] al_mon,
    input  logic [7:0] al_year,
    output logic [7:0] tm_sec,
    output logic [7:0] tm_min,
    output logic [7:0] tm_hour,
    output logic [7:0] tm_day,
    output logic [7:0] tm_mon,
    output logic [7:0] tm_year,
    output logic [2:0] tm_wday,
    output logic       ev_sec,
    output logic       ev_min,
    output logic       ev_hour,
    output logic       ev_day,
    output logic       alarm_hit
);
    logic      tick;
    cal_time_t ld_time, al_time, cur, nxt;

    assign ld_time = '{sec: ld_sec, min: ld_min, hour: ld_hour, day: ld_day, mon: ld_mon, year: ld_year};
    assign al_time = '{sec: al_sec, min: al_min, hour: al_hour, day: al_day, mon: al_mon, year: al_year};

    cal_ctrl #(.PRESCALE_MAX(PRESCALE_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(load_en), .tick(tick));

    cal_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_en),
        .ld_time(ld_time), .ld_wday(ld_wday), .cur(cur), .wday(tm_wday), .nxt(nxt),
        .ev_sec(ev_sec), .ev_min(ev_min), .ev_hour(ev_hour), .ev_day(ev_day));

    cal_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nxt(nxt), .alarm(al_time), .hit(alarm_hit));

    assign tm_sec  = cur.sec;
    assign tm_min  = cur.min;
    assign tm_hour = cur.hour;
    assign tm_day  = cur.day;
    assign tm_mon  = cur.mon;
    assign tm_year = cur.year;

    AST_ALARM_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> ev_sec); // R10
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (tm_sec == $past(ld_sec) && tm_year == $past(ld_year) && !ev_sec)); // R9

endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    localparam int PM = 3;
    localparam int NV = 14;

    logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b1, load_en = 1'b0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_day = 8'h01, ld_mon = 8'h01, ld_year = 0;
    logic [2:0] ld_wday = 0;
    logic [7:0] al_sec = 8'h77, al_min = 0, al_hour = 0, al_day = 8'h01, al_mon = 8'h01, al_year = 0;
    logic [7:0] tm_sec, tm_min, tm_hour, tm_day, tm_mon, tm_year;
    logic [2:0] tm_wday;
    logic ev_sec, ev_min, ev_hour, ev_day, alarm_hit;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    bcd_calendar #(.PRESCALE_MAX(PM)) dut (.*);

    // {start s,m,h,d,mo,y,w} {expected s,m,h,d,mo,y,w} {ev day,hour,min,sec}
    localparam logic [115:0] VEC [NV] = '{
        {56'h00_00_00_01_01_24_00, 56'h01_00_00_01_01_24_00, 4'b0001}, // R2
        {56'h09_00_00_01_01_24_00, 56'h10_00_00_01_01_24_00, 4'b0001}, // R2 digit carry
        {56'h59_00_00_01_01_24_00, 56'h00_01_00_01_01_24_00, 4'b0011}, // R3
        {56'h59_59_09_01_01_24_00, 56'h00_00_10_01_01_24_00, 4'b0111}, // R3
        {56'h59_59_23_15_06_24_03, 56'h00_00_00_16_06_24_04, 4'b1111}, // R6
        {56'h59_59_23_28_02_23_06, 56'h00_00_00_01_03_23_00, 4'b1111}, // R4 non-leap, R6 wrap
        {56'h59_59_23_28_02_24_01, 56'h00_00_00_29_02_24_02, 4'b1111}, // R4 leap
        {56'h59_59_23_29_02_24_01, 56'h00_00_00_01_03_24_02, 4'b1111}, // R4
        {56'h59_59_23_28_02_00_01, 56'h00_00_00_29_02_00_02, 4'b1111}, // R4 year 00 leap
        {56'h59_59_23_30_04_24_01, 56'h00_00_00_01_05_24_02, 4'b1111}, // R4
        {56'h59_59_23_30_05_24_01, 56'h00_00_00_31_05_24_02, 4'b1111}, // R4
        {56'h59_59_23_30_09_24_01, 56'h00_00_00_01_10_24_02, 4'b1111}, // R5 month BCD carry
        {56'h59_59_23_31_12_19_01, 56'h00_00_00_01_01_20_02, 4'b1111}, // R5 year carry
        {56'h59_59_23_31_12_99_05, 56'h00_00_00_01_01_00_06, 4'b1111}  // R5 year wrap
    };

    function automatic logic [55:0] now();
        return {tm_sec, tm_min, tm_hour, tm_day, tm_mon, tm_year, 5'd0, tm_wday};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_time(input logic [55:0] t);
        @(negedge clk);
        {ld_sec, ld_min, ld_hour, ld_day, ld_mon, ld_year} = t[55:8];
        ld_wday = t[2:0];
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset time", 64'(now()), 64'h00_00_00_01_01_00_00);
        chk("R1 reset strobes", 64'({ev_sec, ev_min, ev_hour, ev_day, alarm_hit}), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            load_time(VEC[i][115:60]);
            chk("R9 loaded value", 64'(now()), 64'(VEC[i][115:60]));
            repeat (PM) @(negedge clk);
            chk("R2 no early advance", 64'(now()), 64'(VEC[i][115:60]));
            @(negedge clk);
            chk("R3 R4 R5 R6 advanced time", 64'(now()), 64'(VEC[i][59:4]));
            chk("R7 strobes", 64'({ev_day, ev_hour, ev_min, ev_sec}), 64'(VEC[i][3:0]));
            @(negedge clk);
            chk("R7 strobes one cycle", 64'({ev_day, ev_hour, ev_min, ev_sec}), 64'd0);
        end

        // R9: reload mid-second restarts the prescaler
        load_time(56'h30_10_05_07_08_24_02);
        repeat (2) @(negedge clk);
        load_time(56'h40_10_05_07_08_24_02);
        repeat (PM) @(negedge clk);
        chk("R9 prescaler restart", 64'(now()), 64'h40_10_05_07_08_24_02);
        @(negedge clk);
        chk("R9 full second after load", 64'(now()), 64'h41_10_05_07_08_24_02);

        // R8: freeze while run_en low
        load_time(56'h12_34_11_03_03_24_04);
        run_en = 1'b0;
        repeat (5 * (PM + 1)) begin
            @(negedge clk);
            if (ev_sec) chk("R8 no strobe while halted", 64'd1, 64'd0);
        end
        chk("R8 frozen", 64'(now()), 64'h12_34_11_03_03_24_04);
        run_en = 1'b1;

        // R10: full match fires
        {al_sec, al_min, al_hour, al_day, al_mon, al_year} = 48'h30_20_10_05_06_24;
        load_time(56'h29_20_10_05_06_24_01);
        chk("R10 no hit before match", 64'(alarm_hit), 64'd0);
        repeat (PM + 1) @(negedge clk);
        chk("R10 alarm hit", 64'({alarm_hit, ev_sec}), 64'b11);
        @(negedge clk);
        chk("R10 alarm one cycle", 64'(alarm_hit), 64'd0);

        // R10: year-only mismatch
        al_year = 8'h25;
        load_time(56'h29_20_10_05_06_24_01);
        repeat (PM + 1) @(negedge clk);
        chk("R10 year mismatch no hit", 64'({alarm_hit, ev_sec}), 64'b01);

        // R10: loading the alarm time itself does not fire
        al_year = 8'h24;
        load_time(56'h30_20_10_05_06_24_01);
        chk("R10 load match no hit", 64'(alarm_hit), 64'd0);
        @(negedge clk);
        chk("R10 load match no hit later", 64'(alarm_hit), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule